// File: doc/BRIEF.md
# RGB Panel Sync Timing Generator

This block drives the timing side of a parallel RGB panel. From a source clock it derives a pixel-rate enable through a programmable divider, steps a horizontal pixel counter and a vertical line counter, and decodes from them the horizontal sync, vertical sync and data-enable levels together with a pixel-clock marker. Each dimension is laid out as sync pulse, back porch, active region and front porch. Each of those spans is programmed as its length minus one, so a field value of zero means a span of one.

Software programs the block through a plain write port. The port sets the video enable, the divider, the four polarity inversions, the horizontal and vertical spans and the active size. An interrupt line reports each return to the top of the frame, which is the first source cycle in which VSYNC shows its active level again. The pending bit behind the line is cleared by writing one to it. When video is switched off, the counters return to the origin and every panel output rests at its inactive level. That level takes the current inversion bits into account.

Top module: `lcd_sync_gen`

## Requirements
- R1: After reset, hSyncOut, vSyncOut, dataEnOut, pixClkEnOut, xPos, yPos and irqOut are all 0. Writes at address 0 hold the video enable in bit 0, the interrupt enable in bit 1 and the divider field in bits [15:8].
- R2: Address 2 holds the horizontal sync width in bits [7:0], the back porch in [15:8] and the front porch in [23:16], each as a count minus one. A line lasts (sync+1)+(back+1)+(width+1)+(front+1) pixels, and HSYNC is active for the first sync+1 pixels of each line.
- R3: Address 3 holds the vertical sync width, back porch and front porch in the same positions as R2, counted in lines. A frame lasts the sum of the four vertical spans, and VSYNC is active for every pixel of its first sync+1 lines.
- R4: Address 4 holds the active width minus one in bits [10:0] and the active height minus one in bits [26:16]. Data enable is active exactly when the pixel lies in the active columns (from sync+back+2 for width+1 pixels) and the line lies in the active rows.
- R5: A pixel lasts divider+1 source cycles. pixClkEnOut is active in the last source cycle of each pixel. With a divider field of 0 the divider is bypassed and pixClkEnOut is active in every cycle.
- R6: Address 1 holds the inversion bits: bit 0 for HSYNC, bit 1 for VSYNC, bit 2 for data enable and bit 3 for the pixel-clock marker. A set bit turns the active level of that output from high to low. Each bit acts only on its own output.
- R7: With the interrupt enable set, a pending bit is set on each return to the top of the frame. irqOut rises in the same source cycle in which VSYNC first shows its active level for the new frame. The first frame after enable raises no interrupt.
- R8: Writing 1 to bit 0 of address 5 clears the pending bit. Writing 0 there leaves it unchanged.
- R9: With the interrupt enable clear, no frame return sets the pending bit.
- R10: One cycle after the video enable reads 0, the counters are at zero. From the following cycle, xPos and yPos are 0 and every panel output sits at its inactive level, which equals its inversion bit.
- R11: xPos and yPos give the pixel and line position counted from the start of the sync pulse. They hold for the whole pixel and advance only after a pixel-clock marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rstN | input | 1 | Synchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word address |
| regWdata | input | 32 | Register write data |
| hSyncOut | output | 1 | Horizontal sync after inversion |
| vSyncOut | output | 1 | Vertical sync after inversion |
| dataEnOut | output | 1 | Data enable after inversion |
| pixClkEnOut | output | 1 | Pixel-clock marker after inversion |
| xPos | output | 13 | Pixel position within the line |
| yPos | output | 13 | Line position within the frame |
| irqOut | output | 1 | Frame interrupt (pending bit) |

## Verification
The hardest condition to reach from the ports is the frame return when the divider is not bypassed. The interrupt must then appear in the first source cycle of the new frame's first pixel, and not at the earlier pixel-clock marker that ends the old frame. The stimulus programs very short spans, giving a 10-pixel line and a 7-line frame. It then runs whole frames at divide ratios of one, two and three, and predicts every output in every source cycle from the cycle index alone. Further writes with video stopped then exercise the clear-on-one behaviour and the inverted rest levels separately.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;

  // strobes the control side hands to the datapath each source cycle
  typedef struct packed {
    logic pixStep;    // last source cycle of the current pixel
    logic lineWrap;   // pixStep on the final pixel of a line
    logic frameWrap;  // lineWrap on the final line of a frame
    logic idle;       // video disabled
  } syncStrobe_t;

  typedef enum logic [2:0] {
    REG_CTRL  = 3'd0,
    REG_POL   = 3'd1,
    REG_HTIME = 3'd2,
    REG_VTIME = 3'd3,
    REG_SIZE  = 3'd4,
    REG_IRQ   = 3'd5
  } regSel_t;

endpackage

// File: rtl/lcd_sync_regs.sv
module lcd_sync_regs
  import lcd_sync_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32,
  parameter int PORCH_W = 8,
  parameter int SIZE_W  = 11,
  parameter int DIV_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  input  logic               frameMark,
  output logic               videoEn,
  output logic               irqEn,
  output logic [DIV_W-1:0]   divM1,
  output logic [3:0]         polInv,
  output logic [PORCH_W-1:0] hSyncM1,
  output logic [PORCH_W-1:0] hBackM1,
  output logic [PORCH_W-1:0] hFrontM1,
  output logic [PORCH_W-1:0] vSyncM1,
  output logic [PORCH_W-1:0] vBackM1,
  output logic [PORCH_W-1:0] vFrontM1,
  output logic [SIZE_W-1:0]  widthM1,
  output logic [SIZE_W-1:0]  heightM1,
  output logic               irqOut
);

  localparam int DIV_LSB    = 8;
  localparam int BACK_LSB   = PORCH_W;
  localparam int FRONT_LSB  = 2 * PORCH_W;
  localparam int HEIGHT_LSB = DATA_W / 2;

  logic irqPending;
  logic clearHit;

  assign clearHit = regWe && (regAddr == ADDR_W'(REG_IRQ)) && regWdata[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      videoEn  <= 1'b0;
      irqEn    <= 1'b0;
      divM1    <= '0;
      polInv   <= '0;
      hSyncM1  <= '0;
      hBackM1  <= '0;
      hFrontM1 <= '0;
      vSyncM1  <= '0;
      vBackM1  <= '0;
      vFrontM1 <= '0;
      widthM1  <= '0;
      heightM1 <= '0;
    end else if (regWe) begin
      if (regAddr == ADDR_W'(REG_CTRL)) begin
        videoEn <= regWdata[0];
        irqEn   <= regWdata[1];
        divM1   <= regWdata[DIV_LSB +: DIV_W];
      end
      if (regAddr == ADDR_W'(REG_POL)) begin
        polInv <= regWdata[3:0];
      end
      if (regAddr == ADDR_W'(REG_HTIME)) begin
        hSyncM1  <= regWdata[0 +: PORCH_W];
        hBackM1  <= regWdata[BACK_LSB +: PORCH_W];
        hFrontM1 <= regWdata[FRONT_LSB +: PORCH_W];
      end
      if (regAddr == ADDR_W'(REG_VTIME)) begin
        vSyncM1  <= regWdata[0 +: PORCH_W];
        vBackM1  <= regWdata[BACK_LSB +: PORCH_W];
        vFrontM1 <= regWdata[FRONT_LSB +: PORCH_W];
      end
      if (regAddr == ADDR_W'(REG_SIZE)) begin
        widthM1  <= regWdata[0 +: SIZE_W];
        heightM1 <= regWdata[HEIGHT_LSB +: SIZE_W];
      end
    end
  end

  // a new frame event outranks a simultaneous clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPending <= 1'b0;
    end else if (irqEn && frameMark) begin
      irqPending <= 1'b1;
    end else if (clearHit) begin
      irqPending <= 1'b0;
    end
  end

  assign irqOut = irqPending;

  assert_w1c_clear_R8 : assert property (@(posedge clk) disable iff (!rstN)
    (clearHit && !frameMark) |=> !irqPending);

  assert_no_irq_when_masked_R9 : assert property (@(posedge clk) disable iff (!rstN)
    (!irqEn && !irqPending) |=> !irqPending);

endmodule

// File: rtl/lcd_sync_axis.sv
module lcd_sync_axis #(
  parameter int PORCH_W = 8,
  parameter int SIZE_W  = 11,
  parameter int CNT_W   = SIZE_W + 2
) (
  input  logic [CNT_W-1:0]   cnt,
  input  logic [PORCH_W-1:0] syncM1,
  input  logic [PORCH_W-1:0] backM1,
  input  logic [SIZE_W-1:0]  sizeM1,
  output logic               inSync,
  output logic               inActive
);

  logic [CNT_W-1:0] syncEnd;
  logic [CNT_W-1:0] actStart;
  logic [CNT_W-1:0] actEnd;

  always_comb begin
    syncEnd  = CNT_W'(syncM1) + CNT_W'(1);
    actStart = CNT_W'(syncM1) + CNT_W'(backM1) + CNT_W'(2);
    actEnd   = actStart + CNT_W'(sizeM1) + CNT_W'(1);
    inSync   = (cnt < syncEnd);
    inActive = (cnt >= actStart) && (cnt < actEnd);
  end

endmodule

// File: rtl/lcd_sync_ctrl.sv
module lcd_sync_ctrl
  import lcd_sync_pkg::*;
#(
  parameter int PORCH_W = 8,
  parameter int SIZE_W  = 11,
  parameter int DIV_W   = 8,
  parameter int CNT_W   = SIZE_W + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               videoEn,
  input  logic [DIV_W-1:0]   divM1,
  input  logic [PORCH_W-1:0] hSyncM1,
  input  logic [PORCH_W-1:0] hBackM1,
  input  logic [PORCH_W-1:0] hFrontM1,
  input  logic [PORCH_W-1:0] vSyncM1,
  input  logic [PORCH_W-1:0] vBackM1,
  input  logic [PORCH_W-1:0] vFrontM1,
  input  logic [SIZE_W-1:0]  widthM1,
  input  logic [SIZE_W-1:0]  heightM1,
  output syncStrobe_t        strobe,
  output logic [CNT_W-1:0]   hCnt,
  output logic [CNT_W-1:0]   vCnt
);

  logic [DIV_W-1:0] divCnt;
  logic             bypass;
  logic [CNT_W-1:0] hTotalM1;
  logic [CNT_W-1:0] vTotalM1;

  // four spans, each stored minus one: total minus one is the sum plus three
  always_comb begin
    hTotalM1 = CNT_W'(hSyncM1) + CNT_W'(hBackM1) + CNT_W'(widthM1)
             + CNT_W'(hFrontM1) + CNT_W'(3);
    vTotalM1 = CNT_W'(vSyncM1) + CNT_W'(vBackM1) + CNT_W'(heightM1)
             + CNT_W'(vFrontM1) + CNT_W'(3);
  end

  assign bypass = (divM1 == '0);

  always_comb begin
    strobe.idle      = !videoEn;
    strobe.pixStep   = videoEn && (bypass || (divCnt >= divM1));
    strobe.lineWrap  = strobe.pixStep && (hCnt >= hTotalM1);
    strobe.frameWrap = strobe.lineWrap && (vCnt >= vTotalM1);
  end

  always_ff @(posedge clk) begin
    if (!rstN || !videoEn) begin
      divCnt <= '0;
    end else if (strobe.pixStep) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !videoEn) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (strobe.pixStep) begin
      if (strobe.lineWrap) begin
        hCnt <= '0;
        vCnt <= strobe.frameWrap ? '0 : vCnt + CNT_W'(1);
      end else begin
        hCnt <= hCnt + CNT_W'(1);
      end
    end
  end

  assert_pixel_gap_R5 : assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pixStep && divM1 != '0) |=> (!strobe.pixStep || !$stable(divM1)));

  assert_idle_origin_R10 : assert property (@(posedge clk) disable iff (!rstN)
    !videoEn |=> (hCnt == '0 && vCnt == '0));

  assert_hold_between_steps_R11 : assert property (@(posedge clk) disable iff (!rstN)
    (videoEn && !strobe.pixStep) |=> ($stable(hCnt) && $stable(vCnt)));

endmodule

// File: rtl/lcd_sync_dpath.sv
module lcd_sync_dpath
  import lcd_sync_pkg::*;
#(
  parameter int PORCH_W = 8,
  parameter int SIZE_W  = 11,
  parameter int CNT_W   = SIZE_W + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  syncStrobe_t        strobe,
  input  logic [CNT_W-1:0]   hCnt,
  input  logic [CNT_W-1:0]   vCnt,
  input  logic [3:0]         polInv,
  input  logic [PORCH_W-1:0] hSyncM1,
  input  logic [PORCH_W-1:0] hBackM1,
  input  logic [PORCH_W-1:0] vSyncM1,
  input  logic [PORCH_W-1:0] vBackM1,
  input  logic [SIZE_W-1:0]  widthM1,
  input  logic [SIZE_W-1:0]  heightM1,
  output logic               hSyncOut,
  output logic               vSyncOut,
  output logic               dataEnOut,
  output logic               pixClkEnOut,
  output logic [CNT_W-1:0]   xPos,
  output logic [CNT_W-1:0]   yPos,
  output logic               frameMark
);

  localparam int AXES = 2;

  logic [AXES-1:0] inSync;
  logic [AXES-1:0] inActive;
  logic [CNT_W-1:0]   axCnt  [AXES];
  logic [PORCH_W-1:0] axSync [AXES];
  logic [PORCH_W-1:0] axBack [AXES];
  logic [SIZE_W-1:0]  axSize [AXES];

  // axis 0 is horizontal, axis 1 vertical
  assign axCnt[0]  = hCnt;
  assign axCnt[1]  = vCnt;
  assign axSync[0] = hSyncM1;
  assign axSync[1] = vSyncM1;
  assign axBack[0] = hBackM1;
  assign axBack[1] = vBackM1;
  assign axSize[0] = widthM1;
  assign axSize[1] = heightM1;

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    lcd_sync_axis #(
      .PORCH_W(PORCH_W),
      .SIZE_W (SIZE_W),
      .CNT_W  (CNT_W)
    ) u_axis (
      .cnt     (axCnt[a]),
      .syncM1  (axSync[a]),
      .backM1  (axBack[a]),
      .sizeM1  (axSize[a]),
      .inSync  (inSync[a]),
      .inActive(inActive[a])
    );
  end

  logic dataEnRaw;
  assign dataEnRaw = inActive[0] && inActive[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hSyncOut    <= 1'b0;
      vSyncOut    <= 1'b0;
      dataEnOut   <= 1'b0;
      pixClkEnOut <= 1'b0;
      xPos        <= '0;
      yPos        <= '0;
      frameMark   <= 1'b0;
    end else if (strobe.idle) begin
      hSyncOut    <= polInv[0];
      vSyncOut    <= polInv[1];
      dataEnOut   <= polInv[2];
      pixClkEnOut <= polInv[3];
      xPos        <= '0;
      yPos        <= '0;
      frameMark   <= 1'b0;
    end else begin
      hSyncOut    <= inSync[0] ^ polInv[0];
      vSyncOut    <= inSync[1] ^ polInv[1];
      dataEnOut   <= dataEnRaw ^ polInv[2];
      pixClkEnOut <= strobe.pixStep ^ polInv[3];
      xPos        <= hCnt;
      yPos        <= vCnt;
      frameMark   <= strobe.frameWrap;
    end
  end

  assert_de_outside_sync_R4 : assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.idle && dataEnRaw) |-> (!inSync[0] && !inSync[1]));

  assert_idle_levels_R10 : assert property (@(posedge clk) disable iff (!rstN)
    strobe.idle |=> (pixClkEnOut == $past(polInv[3]) && xPos == '0 && yPos == '0));

endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
  import lcd_sync_pkg::*;
#(
  parameter  int ADDR_W  = 3,
  parameter  int DATA_W  = 32,
  parameter  int PORCH_W = 8,
  parameter  int SIZE_W  = 11,
  parameter  int DIV_W   = 8,
  localparam int CNT_W   = SIZE_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic              hSyncOut,
  output logic              vSyncOut,
  output logic              dataEnOut,
  output logic              pixClkEnOut,
  output logic [CNT_W-1:0]  xPos,
  output logic [CNT_W-1:0]  yPos,
  output logic              irqOut
);

  logic               videoEn;
  logic               irqEn;
  logic [DIV_W-1:0]   divM1;
  logic [3:0]         polInv;
  logic [PORCH_W-1:0] hSyncM1, hBackM1, hFrontM1;
  logic [PORCH_W-1:0] vSyncM1, vBackM1, vFrontM1;
  logic [SIZE_W-1:0]  widthM1, heightM1;
  logic               frameMark;
  syncStrobe_t        strobe;
  logic [CNT_W-1:0]   hCnt, vCnt;

  lcd_sync_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PORCH_W(PORCH_W),
    .SIZE_W (SIZE_W),
    .DIV_W  (DIV_W)
  ) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .frameMark(frameMark),
    .videoEn  (videoEn),
    .irqEn    (irqEn),
    .divM1    (divM1),
    .polInv   (polInv),
    .hSyncM1  (hSyncM1),
    .hBackM1  (hBackM1),
    .hFrontM1 (hFrontM1),
    .vSyncM1  (vSyncM1),
    .vBackM1  (vBackM1),
    .vFrontM1 (vFrontM1),
    .widthM1  (widthM1),
    .heightM1 (heightM1),
    .irqOut   (irqOut)
  );

  lcd_sync_ctrl #(
    .PORCH_W(PORCH_W),
    .SIZE_W (SIZE_W),
    .DIV_W  (DIV_W),
    .CNT_W  (CNT_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .videoEn (videoEn),
    .divM1   (divM1),
    .hSyncM1 (hSyncM1),
    .hBackM1 (hBackM1),
    .hFrontM1(hFrontM1),
    .vSyncM1 (vSyncM1),
    .vBackM1 (vBackM1),
    .vFrontM1(vFrontM1),
    .widthM1 (widthM1),
    .heightM1(heightM1),
    .strobe  (strobe),
    .hCnt    (hCnt),
    .vCnt    (vCnt)
  );

  lcd_sync_dpath #(
    .PORCH_W(PORCH_W),
    .SIZE_W (SIZE_W),
    .CNT_W  (CNT_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .hCnt       (hCnt),
    .vCnt       (vCnt),
    .polInv     (polInv),
    .hSyncM1    (hSyncM1),
    .hBackM1    (hBackM1),
    .vSyncM1    (vSyncM1),
    .vBackM1    (vBackM1),
    .widthM1    (widthM1),
    .heightM1   (heightM1),
    .hSyncOut   (hSyncOut),
    .vSyncOut   (vSyncOut),
    .dataEnOut  (dataEnOut),
    .pixClkEnOut(pixClkEnOut),
    .xPos       (xPos),
    .yPos       (yPos),
    .frameMark  (frameMark)
  );

endmodule

// File: tb/lcd_sync_gen_test.sv
module lcd_sync_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int H_TOTAL = 10;   // 2 sync + 3 back + 4 active + 1 front
  localparam int V_TOTAL = 7;    // 1 sync + 2 back + 3 active + 1 front
  localparam int FRAME   = H_TOTAL * V_TOTAL;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic        hSyncOut, vSyncOut, dataEnOut, pixClkEnOut, irqOut;
  logic [12:0] xPos, yPos;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lcd_sync_gen uut (
    .clk        (clk),
    .rstN       (rstN),
    .regWe      (regWe),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .hSyncOut   (hSyncOut),
    .vSyncOut   (vSyncOut),
    .dataEnOut  (dataEnOut),
    .pixClkEnOut(pixClkEnOut),
    .xPos       (xPos),
    .yPos       (yPos),
    .irqOut     (irqOut)
  );

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  task automatic regWrite(input logic [2:0] addr, input logic [31:0] data);
    @(negedge clk);
    regWe = 1'b1;
    regAddr = addr;
    regWdata = data;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R1 hsync after reset", 32'(hSyncOut), 0);
    check("R1 vsync after reset", 32'(vSyncOut), 0);
    check("R1 de after reset", 32'(dataEnOut), 0);
    check("R1 pclk after reset", 32'(pixClkEnOut), 0);
    check("R1 pos after reset", {xPos[12:0], yPos[12:0]}, 0);
    check("R1 irq after reset", 32'(irqOut), 0);
  endtask

  // enable video and predict every output in every source cycle
  task automatic runScan(input int div, input logic [3:0] pol, input bit irqOn, input int cycles);
    bit pend = 0;
    regWrite(3'd1, {28'd0, pol});
    regWrite(3'd0, {16'd0, 8'(div), 6'd0, irqOn, 1'b1});
    for (int k = 0; k < cycles; k++) begin
      int n, x, y;
      bit hs, vs, de, pc;
      @(negedge clk);
      n = k / (div + 1);
      x = n % H_TOTAL;
      y = (n / H_TOTAL) % V_TOTAL;
      hs = (x < 2);
      vs = (y < 1);
      de = (x >= 5 && x < 9) && (y >= 3 && y < 6);
      pc = ((k % (div + 1)) == div);
      if (irqOn && n > 0 && (n % FRAME) == 0 && (k % (div + 1)) == 0) pend = 1;
      check("R2 hsync level", 32'(hSyncOut), 32'(hs ^ pol[0]));
      check("R3 vsync level", 32'(vSyncOut), 32'(vs ^ pol[1]));
      check("R4 data enable", 32'(dataEnOut), 32'(de ^ pol[2]));
      check("R5 pixel clock marker", 32'(pixClkEnOut), 32'(pc ^ pol[3]));
      check("R6 R11 position x", 32'(xPos), 32'(x));
      check("R11 position y", 32'(yPos), 32'(y));
      if (irqOn) check("R7 frame irq", 32'(irqOut), 32'(pend));
      else       check("R9 masked irq", 32'(irqOut), 0);
    end
  endtask

  task automatic testStop(input logic [3:0] pol);
    regWrite(3'd0, 32'd0);
    @(negedge clk);
    check("R10 R6 hsync rest", 32'(hSyncOut), 32'(pol[0]));
    check("R10 R6 vsync rest", 32'(vSyncOut), 32'(pol[1]));
    check("R10 R6 de rest", 32'(dataEnOut), 32'(pol[2]));
    check("R10 R6 pclk rest", 32'(pixClkEnOut), 32'(pol[3]));
    check("R10 position rest", {xPos[12:0], yPos[12:0]}, 0);
    repeat (4) @(negedge clk);
    check("R10 pclk stays at rest", 32'(pixClkEnOut), 32'(pol[3]));
  endtask

  task automatic testClear();
    check("R7 pending held while stopped", 32'(irqOut), 1);
    regWrite(3'd5, 32'd0);
    @(negedge clk);
    check("R8 writing zero keeps pending", 32'(irqOut), 1);
    regWrite(3'd5, 32'd1);
    check("R8 writing one clears pending", 32'(irqOut), 0);
    @(negedge clk);
    check("R8 pending stays clear", 32'(irqOut), 0);
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    regWrite(3'd2, 32'h0000_0201);  // hsync 2, back 3, front 1
    regWrite(3'd3, 32'h0000_0100);  // vsync 1, back 2, front 1
    regWrite(3'd4, 32'h0002_0003);  // width 4, height 3
    runScan(0, 4'b0000, 1'b1, 2 * FRAME + 10);
    testStop(4'b0000);
    testClear();
    runScan(2, 4'b1111, 1'b0, 3 * FRAME + 20);
    testStop(4'b1111);
    runScan(1, 4'b0101, 1'b1, 2 * FRAME + 10);
    testStop(4'b0101);
    finishRun();
  end

endmodule